// File: doc/BRIEF.md
# Condition-Code Integer ALU

This block is the combinational arithmetic and logic stage of a 16-bit minicomputer datapath. Given an operation code, a source operand, a destination operand, the current condition codes and a byte/word selector, it returns the value to be written back and the new negative, zero, overflow and carry flags. It has no clock and no state. Operand fetch, writeback, multiply/divide and multi-position shifts belong to neighbouring blocks.

Each operation has its own rule for the flags. Some keep the incoming carry, some force it, and some compute it as a borrow. Outside those rules, N follows the sign of the result and Z flags an all-zero result. In byte mode the operation works on the low eight bits and bit 7 serves as the sign. The upper byte of the result carries the destination's upper byte through unchanged, except for a byte move, which sign-extends.

Top module: `alu_nzvc`

## Requirements
- R1: The flag vectors are packed N,Z,V,C from bit 3 down to bit 0, and the incoming carry is bit 0 of `flags_i`. Opcodes are 0 clr, 1 com, 2 inc, 3 dec, 4 neg, 5 tst, 6 adc, 7 sbc, 8 asr, 9 asl, 10 ror, 11 rol, 12 swab, 13 sxt, 14 mov, 15 add, 16 sub, 17 cmp, 18 bit, 19 bic, 20 bis, 21 xor, and codes 22..31 behave as tst. For every operation, N equals the sign bit of the active width of the result and Z is set exactly when that width is zero.
- R2: clr returns 0 with N=0, Z=1, V=0, C=0. com returns ~dst with V=0, C=1. tst returns dst with V=0, C=0.
- R3: inc and dec return dst+1 and dst-1 and keep C. V is set for inc when dst is 0x7FFF and for dec when dst is 0x8000.
- R4: neg returns 0-dst. V is set when the result is 0x8000 and C is set when the result is nonzero.
- R5: add returns dst+src and C is the carry out of the sign bit. V is set when src and dst have the same sign and the result's sign differs from it.
- R6: sub returns dst-src and cmp returns src-dst. For both, C is the borrow (set when the minuend is unsigned-below the subtrahend) and V is set when the operands' signs differ and the result's sign differs from the minuend's sign.
- R7: asr and ror shift right and take C from bit 0 of dst. asr replicates the sign bit and ror inserts the old C. asl and rol shift left and take C from the sign bit of dst. asl inserts 0 and rol inserts the old C. For all four, V = N xor C of the new flags.
- R8: adc returns dst+C, sets V when dst is 0x7FFF and C=1, and sets C when dst is 0xFFFF and C=1. sbc returns dst-C, sets V when dst is 0x8000, and sets C unless dst is 0 and C=1.
- R9: mov returns src. bit returns src&dst, bic returns dst&~src, bis returns dst|src and xor returns dst^src. All five clear V and keep C.
- R10: swab exchanges the bytes of dst and clears V and C. sxt returns all ones if the old N is 1 and all zeros otherwise, keeps N, V and C, and sets Z to the inverse of the old N. Both always work on the full word, whatever the byte bit says.
- R11: With `byte_i`=1, every other operation computes on bits 7..0 and takes its sign, carry and overflow at bit 7, using 0x7F, 0x80 and 0xFF as the special values. Result bits 15..8 equal dst bits 15..8.
- R12: A byte-mode mov returns src bits 7..0 with bit 7 copied into bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (R1 encoding) |
| byte_i | input | 1 | 1 selects byte mode |
| src_i | input | WIDTH (16) | Source operand |
| dst_i | input | WIDTH (16) | Destination operand |
| flags_i | input | 4 | Current N,Z,V,C (bit 0 is carry-in) |
| result_o | output | WIDTH (16) | Computed value |
| flags_o | output | 4 | New N,Z,V,C |

## Verification
The bound checker continuously tests the properties that tie the flag unit to the datapath. It checks that N and Z agree with the sign and zero-ness of the result at the active width, that inc and dec never disturb C, that neg's carry tracks a nonzero result, that shifts satisfy V = N xor C, that logic operations clear V and keep C, and that byte mode preserves or sign-extends the upper byte. The exact values of results and flags cannot be checked that way and are left to the bench's scenarios. These include the overflow thresholds of inc, dec, adc and sbc, the borrow sense of sub and cmp with their opposite operand orders, the bits that rotates insert, and the treatment of the byte lane at 0x7F and 0x80.

// File: rtl/alu_nzvc_pkg.sv
// Shared definitions for the condition-code ALU.
// Assumes a 5-bit operation code; codes above OP_XOR behave as a test.
package alu_nzvc_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_CLR  = 5'd0,
        OP_COM  = 5'd1,
        OP_INC  = 5'd2,
        OP_DEC  = 5'd3,
        OP_NEG  = 5'd4,
        OP_TST  = 5'd5,
        OP_ADC  = 5'd6,
        OP_SBC  = 5'd7,
        OP_ASR  = 5'd8,
        OP_ASL  = 5'd9,
        OP_ROR  = 5'd10,
        OP_ROL  = 5'd11,
        OP_SWAB = 5'd12,
        OP_SXT  = 5'd13,
        OP_MOV  = 5'd14,
        OP_ADD  = 5'd15,
        OP_SUB  = 5'd16,
        OP_CMP  = 5'd17,
        OP_BIT  = 5'd18,
        OP_BIC  = 5'd19,
        OP_BIS  = 5'd20,
        OP_XOR  = 5'd21
    } alu_op_e;

    // Flags packed N (bit 3), Z, V, C (bit 0).
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/alu_lane.sv
// One ALU lane of width W: computes the result and all four flags for
// every operation at that width. Assumes W is even and at least 4.
// Used once at full word width and once at byte width.
module alu_lane
    import alu_nzvc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   src,
    input  logic [W-1:0]   dst,
    input  nzvc_t          fin,
    output logic [W-1:0]   res,
    output nzvc_t          fout
);

    localparam int          MSB     = W - 1;
    localparam int          HALF    = W / 2;
    localparam logic [W-1:0] ZERO    = '0;
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALL_ONE = '1;
    localparam logic [W-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

    logic [W:0]   wide;
    logic [W-1:0] minu;
    logic [W-1:0] subt;
    nzvc_t        fl;

    // Pick the minuend and subtrahend: cmp subtracts dst from src.
    always_comb begin
        minu = (op == OP_CMP) ? src : dst;
        subt = (op == OP_CMP) ? dst : src;
    end

    // Per-operation result and V/C rules, then the N/Z rule.
    always_comb begin
        res  = dst;
        wide = '0;
        fl   = '0;
        fl.c = fin.c;
        case (op)
            OP_CLR: begin res = ZERO; fl.c = 1'b0; end
            OP_COM: begin res = ~dst; fl.c = 1'b1; end
            OP_INC: begin res = dst + ONE; fl.v = (dst == MAX_POS); end
            OP_DEC: begin res = dst - ONE; fl.v = (dst == MIN_NEG); end
            OP_NEG: begin
                res  = ZERO - dst;
                fl.v = (res == MIN_NEG);
                fl.c = (res != ZERO);
            end
            OP_ADC: begin
                wide = {1'b0, dst} + {{W{1'b0}}, fin.c};
                res  = wide[W-1:0];
                fl.v = (dst == MAX_POS) && fin.c;
                fl.c = (dst == ALL_ONE) && fin.c;
            end
            OP_SBC: begin
                res  = dst - {{(W-1){1'b0}}, fin.c};
                fl.v = (dst == MIN_NEG);
                fl.c = !((dst == ZERO) && fin.c);
            end
            OP_ASR: begin res = {dst[MSB], dst[MSB:1]};   fl.c = dst[0];   fl.v = res[MSB] ^ fl.c; end
            OP_ASL: begin res = {dst[MSB-1:0], 1'b0};     fl.c = dst[MSB]; fl.v = res[MSB] ^ fl.c; end
            OP_ROR: begin res = {fin.c, dst[MSB:1]};      fl.c = dst[0];   fl.v = res[MSB] ^ fl.c; end
            OP_ROL: begin res = {dst[MSB-1:0], fin.c};    fl.c = dst[MSB]; fl.v = res[MSB] ^ fl.c; end
            OP_SWAB: begin res = {dst[HALF-1:0], dst[W-1:HALF]}; fl.c = 1'b0; end
            OP_SXT: begin res = {W{fin.n}}; fl.v = fin.v; end
            OP_MOV: res = src;
            OP_ADD: begin
                wide = {1'b0, dst} + {1'b0, src};
                res  = wide[W-1:0];
                fl.c = wide[W];
                fl.v = (src[MSB] == dst[MSB]) && (res[MSB] != src[MSB]);
            end
            OP_SUB, OP_CMP: begin
                wide = {1'b0, minu} - {1'b0, subt};
                res  = wide[W-1:0];
                fl.c = wide[W];
                fl.v = (minu[MSB] != subt[MSB]) && (res[MSB] != minu[MSB]);
            end
            OP_BIT: res = src & dst;
            OP_BIC: res = dst & ~src;
            OP_BIS: res = dst | src;
            OP_XOR: res = dst ^ src;
            default: begin res = dst; fl.c = 1'b0; end
        endcase
        fl.n = (op == OP_SXT) ? fin.n  : res[MSB];
        fl.z = (op == OP_SXT) ? !fin.n : (res == ZERO);
        fout = fl;
    end

endmodule

// File: rtl/alu_merge.sv
// Chooses between the full-width lane and the byte lane and builds the
// upper byte in byte mode: dst passes through, a byte move sign-extends.
// Assumes H is W/2; swab and sxt always take the full lane.
module alu_merge
    import alu_nzvc_pkg::*;
#(
    parameter int W = 16,
    parameter int H = W / 2
) (
    input  alu_op_e          op,
    input  logic             byte_mode,
    input  logic [W-H-1:0]   dst_hi,
    input  logic [W-1:0]     full_res,
    input  nzvc_t            full_fl,
    input  logic [H-1:0]     half_res,
    input  nzvc_t            half_fl,
    output logic [W-1:0]     res,
    output nzvc_t            fl
);

    logic use_half;

    // Byte lane only when byte mode is asked for and the op honours it.
    always_comb use_half = byte_mode && (op != OP_SWAB) && (op != OP_SXT);

    // Assemble the outgoing word and flags.
    always_comb begin
        if (!use_half) begin
            res = full_res;
            fl  = full_fl;
        end else begin
            fl = half_fl;
            if (op == OP_MOV) res = {{(W-H){half_res[H-1]}}, half_res};
            else              res = {dst_hi, half_res};
        end
    end

endmodule

// File: rtl/alu_nzvc.sv
// Top of the condition-code ALU: purely combinational. Runs a full-width
// and a byte-width lane side by side and merges them per the byte bit.
// Assumes WIDTH is even.
module alu_nzvc
    import alu_nzvc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic             byte_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [3:0]       flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_o
);

    localparam int HW = WIDTH / 2;

    alu_op_e         op;
    nzvc_t           fin;
    logic [WIDTH-1:0] full_res;
    nzvc_t           full_fl;
    logic [HW-1:0]   half_res;
    nzvc_t           half_fl;
    logic [WIDTH-1:0] res;
    nzvc_t           fl;

    // Decode raw input vectors into typed form.
    always_comb begin
        op  = alu_op_e'(op_i);
        fin = nzvc_t'(flags_i);
    end

    alu_lane #(.W(WIDTH)) u_full (
        .op   (op),
        .src  (src_i),
        .dst  (dst_i),
        .fin  (fin),
        .res  (full_res),
        .fout (full_fl)
    );

    alu_lane #(.W(HW)) u_half (
        .op   (op),
        .src  (src_i[HW-1:0]),
        .dst  (dst_i[HW-1:0]),
        .fin  (fin),
        .res  (half_res),
        .fout (half_fl)
    );

    alu_merge #(.W(WIDTH), .H(HW)) u_merge (
        .op        (op),
        .byte_mode (byte_i),
        .dst_hi    (dst_i[WIDTH-1:HW]),
        .full_res  (full_res),
        .full_fl   (full_fl),
        .half_res  (half_res),
        .half_fl   (half_fl),
        .res       (res),
        .fl        (fl)
    );

    // Drive the ports.
    always_comb begin
        result_o = res;
        flags_o  = fl;
    end

endmodule

// File: rtl/alu_nzvc_chk.sv
// Property checker for alu_nzvc, bound to every instance. The block has
// no clock, so all checks are immediate assertions on settled values.
module alu_nzvc_chk
    import alu_nzvc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic [OP_W-1:0]  op_i,
    input logic             byte_i,
    input logic [WIDTH-1:0] src_i,
    input logic [WIDTH-1:0] dst_i,
    input logic [3:0]       flags_i,
    input logic [WIDTH-1:0] result_o,
    input logic [3:0]       flags_o
);

    localparam int HW = WIDTH / 2;

    logic act_byte;
    logic sgn;
    logic zer;
    logic [4:0] opv;

    // Active width and its sign/zero view of the result.
    always_comb begin
        opv      = op_i;
        act_byte = byte_i && (opv != 5'd12) && (opv != 5'd13);
        sgn      = act_byte ? result_o[HW-1] : result_o[WIDTH-1];
        zer      = act_byte ? (result_o[HW-1:0] == '0) : (result_o == '0);
    end

    // Flag/result consistency checks.
    always_comb begin
        p_n_sign_r1: assert (flags_o[3] == sgn)
            else $error("N does not match result sign");
        p_z_zero_r1: assert (flags_o[2] == zer)
            else $error("Z does not match zero result");
        p_clr_flags_r2: assert (!(opv == 5'd0) || (flags_o[1:0] == 2'b00 && zer))
            else $error("clr flags wrong");
        p_keep_c_r3: assert (!(opv == 5'd2 || opv == 5'd3) || (flags_o[0] == flags_i[0]))
            else $error("inc/dec changed C");
        p_neg_c_r4: assert (!(opv == 5'd4) || (flags_o[0] == !zer))
            else $error("neg C not tied to nonzero result");
        p_shift_v_r7: assert (!(opv >= 5'd8 && opv <= 5'd11) || (flags_o[1] == (flags_o[3] ^ flags_o[0])))
            else $error("shift V != N^C");
        p_logic_vc_r9: assert (!(opv == 5'd14 || (opv >= 5'd18 && opv <= 5'd21))
                               || (!flags_o[1] && flags_o[0] == flags_i[0]))
            else $error("logic op V/C wrong");
        p_byte_hi_r11: assert (!(act_byte && opv != 5'd14) || (result_o[WIDTH-1:HW] == dst_i[WIDTH-1:HW]))
            else $error("byte mode upper byte disturbed");
        p_byte_mov_r12: assert (!(act_byte && opv == 5'd14) || (result_o[WIDTH-1:HW] == {HW{src_i[HW-1]}}))
            else $error("byte move not sign-extended");
    end

endmodule

bind alu_nzvc alu_nzvc_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_nzvc.sv
// Self-checking bench for alu_nzvc: a vector table, then directed sweeps.
module tb_alu_nzvc;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 47;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] result_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_nzvc dut (
        .op_i(op_i), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
    );

    // Fields: op, byte, src, dst, flags in, expected result, expected flags, req.
    localparam logic [65:0] VEC [NV] = '{
        {5'd0,  1'b0, 16'h1234, 16'hABCD, 4'hF, 16'h0000, 4'h4, 4'd2},  // R2 clr
        {5'd1,  1'b0, 16'h0000, 16'h00FF, 4'h0, 16'hFF00, 4'h9, 4'd2},  // R2 com
        {5'd5,  1'b0, 16'h0000, 16'h8000, 4'h3, 16'h8000, 4'h8, 4'd2},  // R2 tst
        {5'd5,  1'b0, 16'h0000, 16'h0000, 4'hF, 16'h0000, 4'h4, 4'd1},  // R1 zero
        {5'd2,  1'b0, 16'h0000, 16'h7FFF, 4'h1, 16'h8000, 4'hB, 4'd3},  // R3 inc ovf
        {5'd2,  1'b0, 16'h0000, 16'hFFFF, 4'h0, 16'h0000, 4'h4, 4'd3},  // R3 inc wrap
        {5'd3,  1'b0, 16'h0000, 16'h8000, 4'h0, 16'h7FFF, 4'h2, 4'd3},  // R3 dec ovf
        {5'd3,  1'b0, 16'h0000, 16'h0001, 4'h1, 16'h0000, 4'h5, 4'd3},  // R3 dec zero
        {5'd4,  1'b0, 16'h0000, 16'h0001, 4'h0, 16'hFFFF, 4'h9, 4'd4},  // R4
        {5'd4,  1'b0, 16'h0000, 16'h8000, 4'h0, 16'h8000, 4'hB, 4'd4},  // R4
        {5'd4,  1'b0, 16'h0000, 16'h0000, 4'hF, 16'h0000, 4'h4, 4'd4},  // R4
        {5'd15, 1'b0, 16'h7FFF, 16'h0001, 4'h0, 16'h8000, 4'hA, 4'd5},  // R5
        {5'd15, 1'b0, 16'hFFFF, 16'h0001, 4'h0, 16'h0000, 4'h5, 4'd5},  // R5
        {5'd15, 1'b0, 16'h8000, 16'h8000, 4'h0, 16'h0000, 4'h7, 4'd5},  // R5
        {5'd16, 1'b0, 16'h0001, 16'h0000, 4'h0, 16'hFFFF, 4'h9, 4'd6},  // R6 sub
        {5'd16, 1'b0, 16'h0001, 16'h8000, 4'h0, 16'h7FFF, 4'h2, 4'd6},  // R6 sub
        {5'd17, 1'b0, 16'h0005, 16'h0003, 4'h0, 16'h0002, 4'h0, 4'd6},  // R6 cmp
        {5'd17, 1'b0, 16'h0003, 16'h0005, 4'h0, 16'hFFFE, 4'h9, 4'd6},  // R6 cmp
        {5'd17, 1'b0, 16'hFFFF, 16'h8000, 4'h0, 16'h7FFF, 4'h0, 4'd6},  // R6 cmp
        {5'd8,  1'b0, 16'h0000, 16'h8001, 4'h0, 16'hC000, 4'h9, 4'd7},  // R7 asr
        {5'd9,  1'b0, 16'h0000, 16'h4000, 4'h0, 16'h8000, 4'hA, 4'd7},  // R7 asl
        {5'd10, 1'b0, 16'h0000, 16'h0001, 4'h0, 16'h0000, 4'h7, 4'd7},  // R7 ror
        {5'd11, 1'b0, 16'h0000, 16'h8000, 4'h1, 16'h0001, 4'h3, 4'd7},  // R7 rol
        {5'd6,  1'b0, 16'h0000, 16'h7FFF, 4'h1, 16'h8000, 4'hA, 4'd8},  // R8 adc
        {5'd6,  1'b0, 16'h0000, 16'hFFFF, 4'h1, 16'h0000, 4'h5, 4'd8},  // R8 adc
        {5'd6,  1'b0, 16'h0000, 16'hFFFF, 4'h0, 16'hFFFF, 4'h8, 4'd8},  // R8 adc
        {5'd7,  1'b0, 16'h0000, 16'h0000, 4'h1, 16'hFFFF, 4'h8, 4'd8},  // R8 sbc
        {5'd7,  1'b0, 16'h0000, 16'h8000, 4'h0, 16'h8000, 4'hB, 4'd8},  // R8 sbc
        {5'd14, 1'b0, 16'h8000, 16'h1234, 4'h3, 16'h8000, 4'h9, 4'd9},  // R9 mov
        {5'd18, 1'b0, 16'h00F0, 16'h0F0F, 4'h2, 16'h0000, 4'h4, 4'd9},  // R9 bit
        {5'd19, 1'b0, 16'h00FF, 16'h1234, 4'h1, 16'h1200, 4'h1, 4'd9},  // R9 bic
        {5'd20, 1'b0, 16'h8000, 16'h0001, 4'h2, 16'h8001, 4'h8, 4'd9},  // R9 bis
        {5'd21, 1'b0, 16'hFFFF, 16'h0F0F, 4'h1, 16'hF0F0, 4'h9, 4'd9},  // R9 xor
        {5'd12, 1'b0, 16'h0000, 16'h1280, 4'hF, 16'h8012, 4'h8, 4'd10}, // R10 swab
        {5'd13, 1'b0, 16'h0000, 16'h1234, 4'h8, 16'hFFFF, 4'h8, 4'd10}, // R10 sxt
        {5'd13, 1'b0, 16'h0000, 16'h1234, 4'h3, 16'h0000, 4'h7, 4'd10}, // R10 sxt
        {5'd12, 1'b1, 16'h0000, 16'h1280, 4'hF, 16'h8012, 4'h8, 4'd10}, // R10 swab byte
        {5'd2,  1'b1, 16'h0000, 16'hAB7F, 4'h0, 16'hAB80, 4'hA, 4'd11}, // R11 incb
        {5'd15, 1'b1, 16'h0080, 16'h1280, 4'h0, 16'h1200, 4'h7, 4'd11}, // R11 addb
        {5'd0,  1'b1, 16'h0000, 16'hFFFF, 4'hF, 16'hFF00, 4'h4, 4'd11}, // R11 clrb
        {5'd17, 1'b1, 16'h0001, 16'h0002, 4'h0, 16'h00FF, 4'h9, 4'd11}, // R11 cmpb
        {5'd4,  1'b1, 16'h0000, 16'h5580, 4'h0, 16'h5580, 4'hB, 4'd11}, // R11 negb
        {5'd9,  1'b1, 16'h0000, 16'h0040, 4'h0, 16'h0080, 4'hA, 4'd11}, // R11 aslb
        {5'd10, 1'b1, 16'h0000, 16'h0100, 4'h1, 16'h0180, 4'hA, 4'd11}, // R11 rorb
        {5'd14, 1'b1, 16'h0080, 16'h1234, 4'h0, 16'hFF80, 4'h8, 4'd12}, // R12
        {5'd14, 1'b1, 16'hFF7F, 16'h1234, 4'h1, 16'h007F, 4'h1, 4'd12}, // R12
        {5'd22, 1'b0, 16'h0000, 16'h8000, 4'h3, 16'h8000, 4'h8, 4'd1}   // R1 unused
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic bm, input logic [15:0] s,
                         input logic [15:0] d, input logic [3:0] f);
        @(posedge clk);
        op_i = op; byte_i = bm; src_i = s; dst_i = d; flags_i = f;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // Reset window: all inputs zero means clr of zero (R2).
        repeat (3) @(negedge clk);
        check(2, "reset-time result", result_o, 16'h0000);
        check(2, "reset-time flags", {12'h0, flags_o}, 16'h0004);
        rst_n = 1'b1;

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][65:61], VEC[i][60], VEC[i][59:44], VEC[i][43:28], VEC[i][27:24]);
            check(int'(VEC[i][3:0]), $sformatf("vec %0d result", i), result_o, VEC[i][23:8]);
            check(int'(VEC[i][3:0]), $sformatf("vec %0d flags", i), {12'h0, flags_o}, {12'h0, VEC[i][7:4]});
        end

        // R11: byte increment over every low-byte value, upper byte held.
        for (int k = 0; k < 256; k++) begin
            logic [7:0] nb;
            logic [3:0] ef;
            nb = 8'(k + 1);
            ef = {nb[7], nb == 8'h00, k == 8'h7F, 1'b1};
            apply(5'd2, 1'b1, 16'h0000, {8'hA5, 8'(k)}, 4'h1);
            check(11, "incb sweep result", result_o, {8'hA5, nb});
            check(11, "incb sweep flags", {12'h0, flags_o}, {12'h0, ef});
        end

        // R5 / R6: word add and sub against computed sums.
        for (int k = 0; k < 64; k++) begin
            logic [15:0] a;
            logic [15:0] b;
            logic [16:0] s;
            a = 16'(k * 16'h0A37);
            b = 16'(16'hF00F - k * 16'h0411);
            s = {1'b0, b} + {1'b0, a};
            apply(5'd15, 1'b0, a, b, 4'h0);
            check(5, "add sweep result", result_o, s[15:0]);
            check(5, "add sweep C", {15'h0, flags_o[0]}, {15'h0, s[16]});
            apply(5'd16, 1'b0, a, b, 4'h0);
            check(6, "sub sweep result", result_o, 16'(b - a));
            check(6, "sub sweep C", {15'h0, flags_o[0]}, {15'h0, b < a});
        end

        // R9: C passes through the logic ops both ways.
        for (int c = 0; c < 2; c++) begin
            apply(5'd20, 1'b0, 16'h0F00, 16'h00F0, {3'b001, 1'(c)});
            check(9, "bis keeps C", {15'h0, flags_o[0]}, 16'(c));
            check(9, "bis result", result_o, 16'h0FF0);
        end

        finish_run();
    end

endmodule